// File: doc/BRIEF.md
# Fully Associative Tag Directory with Switchable Replacement

This block holds the tags, valid bits and recency order for a small fully associative cache of four two-word lines. Each cycle it can accept one word-address reference, marked by a one-cycle strobe. Because every line can hold any block, the address has no index field. Bit 0 selects the word inside the block, and bits 15:1 are the tag, which is compared against every valid line at once.

On a hit, the directory reports the matching line. On a miss, it allocates a line, and the fill is taken to complete in the same cycle. While any line is still empty, the lowest-numbered empty line is used. Once all lines are full, a run-time select input chooses the victim: either the line touched longest ago or the line touched most recently.

Both policies use one shared rank list, and that list is updated on every reference. The block also keeps running counts of references and misses, so a miss ratio can be formed outside. Data storage, memory traffic and write handling belong to other blocks.

Top module: `fa_tag_dir`

## Requirements
- R1: While rst_n is low, all lines become invalid, both counters go to zero and rsp_valid goes low; the first reference after reset misses and fills line 0.
- R2: Address bit 0 is the word offset and takes no part in matching: two addresses that differ only in bit 0 map to the same line, and the second one hits.
- R3: A reference whose bits 15:1 equal the tag of a valid line is a hit. One clock edge after the strobe, rsp_hit is 1 and rsp_line gives that line.
- R4: A miss while at least one line is invalid fills the lowest-numbered invalid line, whatever the policy select.
- R5: With policy_sel = 0 (least recent) and all lines valid, a miss replaces the line whose last reference is oldest.
- R6: With policy_sel = 1 (most recent) and all lines valid, a miss replaces the line referenced most recently.
- R7: A hit or a fill makes the touched line the most recent one, and all other lines keep their relative order. The four ranks always stay a permutation of 0..3.
- R8: Changing policy_sel changes only later victim choices. No line is invalidated or retagged, and every line present before the change still hits afterwards.
- R9: ref_count increases by one for each strobed reference, and miss_count by one for each miss. Neither counter changes in a cycle without a strobe.
- R10: rsp_valid is 1 exactly in the cycle after a strobed reference and 0 otherwise.
- R11: At most one valid line matches any lookup tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| ref_valid | input | 1 | One-cycle strobe marking a reference |
| ref_addr | input | 16 | Word address of the reference |
| policy_sel | input | 1 | Victim policy: 0 least recent, 1 most recent |
| rsp_valid | output | 1 | Result valid, one edge after the strobe |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_line | output | 2 | Line that was hit or filled |
| ref_count | output | 16 | Running count of references |
| miss_count | output | 16 | Running count of misses |

## Verification
Every result is produced by registers loaded on the edge that samples the strobe. The bench therefore drives a reference on a falling edge and reads rsp_valid, rsp_hit, rsp_line and both counters at the next falling edge, one full register stage later. During an idle cycle inserted after a reference, the bench expects rsp_valid to drop and the counters to hold. The bench's reference model uses per-line timestamps, not a rank list, to predict which line is hit or chosen as victim.

// File: rtl/fa_tag_dir_pkg.sv
package fa_tag_dir_pkg;
  typedef enum logic {
    POL_OLDEST = 1'b0,
    POL_NEWEST = 1'b1
  } repl_pol_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 15,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_LINES-1:0][TAG_W-1:0] tag_tbl,
  input  logic [NUM_LINES-1:0]            valid_tbl,
  input  logic [TAG_W-1:0]                lookup_tag,
  output logic [NUM_LINES-1:0]            hit_vec,
  output logic                            hit_any,
  output logic [IDX_W-1:0]                hit_idx
);
  // one comparator per line, all in parallel
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
    assign hit_vec[g] = valid_tbl[g] && (tag_tbl[g] == lookup_tag);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_recency.sv
module fa_recency
  import fa_tag_dir_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            touch_en,
  input  logic [IDX_W-1:0]                touch_idx,
  input  repl_pol_e                       pol,
  output logic [NUM_LINES-1:0][IDX_W-1:0] rank_q,
  output logic [IDX_W-1:0]                victim_idx
);
  localparam logic [IDX_W-1:0] TOP_RANK = IDX_W'(NUM_LINES - 1);

  logic [NUM_LINES-1:0][IDX_W-1:0] rank_d;
  logic [IDX_W-1:0]                old_rank;
  logic [IDX_W-1:0]                want_rank;

  // next-state: touched line to top, lines above it slide down by one
  always_comb begin
    old_rank = rank_q[touch_idx];
    for (int i = 0; i < NUM_LINES; i++) begin
      if (IDX_W'(i) == touch_idx)       rank_d[i] = TOP_RANK;
      else if (rank_q[i] > old_rank)    rank_d[i] = rank_q[i] - 1'b1;
      else                              rank_d[i] = rank_q[i];
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_rank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rank_q[g] <= IDX_W'(g);
      else if (touch_en) rank_q[g] <= rank_d[g];
    end
  end

  // victim: rank 0 for oldest, top rank for newest
  always_comb begin
    want_rank  = (pol == POL_NEWEST) ? TOP_RANK : '0;
    victim_idx = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (rank_q[i] == want_rank) victim_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_alloc_sel.sv
module fa_alloc_sel #(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_LINES-1:0] valid_tbl,
  input  logic                 hit_any,
  input  logic [IDX_W-1:0]     hit_idx,
  input  logic [IDX_W-1:0]     victim_idx,
  output logic [IDX_W-1:0]     line_sel
);
  logic             free_any;
  logic [IDX_W-1:0] free_idx;

  assign free_any = ~&valid_tbl;

  // lowest-numbered free line wins: scan downward, last write sticks
  always_comb begin
    free_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (!valid_tbl[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (hit_any)       line_sel = hit_idx;
    else if (free_any) line_sel = free_idx;
    else               line_sel = victim_idx;
  end
endmodule

// File: rtl/fa_ref_counters.sv
module fa_ref_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_ref,
  input  logic             inc_miss,
  output logic [CNT_W-1:0] ref_cnt_q,
  output logic [CNT_W-1:0] miss_cnt_q
);
  logic [CNT_W-1:0] ref_cnt_d;
  logic [CNT_W-1:0] miss_cnt_d;

  always_comb begin
    ref_cnt_d  = ref_cnt_q + CNT_W'(1);
    miss_cnt_d = miss_cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ref_cnt_q <= '0;
    else if (inc_ref) ref_cnt_q <= ref_cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        miss_cnt_q <= '0;
    else if (inc_miss) miss_cnt_q <= miss_cnt_d;
  end
endmodule

// File: rtl/fa_tag_dir.sv
module fa_tag_dir
  import fa_tag_dir_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OFF_W     = 1,
  parameter int NUM_LINES = 4,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              policy_sel,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_line,
  output logic [CNT_W-1:0]  ref_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [NUM_LINES-1:0][TAG_W-1:0] tag_q;
  logic [NUM_LINES-1:0]            valid_q;
  logic [NUM_LINES-1:0]            valid_d;
  logic [TAG_W-1:0]                lookup_tag;
  logic [NUM_LINES-1:0]            hit_vec;
  logic                            hit_any;
  logic [IDX_W-1:0]                hit_idx;
  logic [IDX_W-1:0]                victim_idx;
  logic [IDX_W-1:0]                line_sel;
  logic [NUM_LINES-1:0][IDX_W-1:0] rank_q;
  logic                            fill_en;
  repl_pol_e                       pol;

  assign lookup_tag = ref_addr[ADDR_W-1:OFF_W];
  assign pol        = repl_pol_e'(policy_sel);
  assign fill_en    = ref_valid && !hit_any;

  fa_tag_match #(
    .NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)
  ) u_match (
    .tag_tbl   (tag_q),
    .valid_tbl (valid_q),
    .lookup_tag(lookup_tag),
    .hit_vec   (hit_vec),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx)
  );

  fa_recency #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)
  ) u_recency (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (ref_valid),
    .touch_idx (line_sel),
    .pol       (pol),
    .rank_q    (rank_q),
    .victim_idx(victim_idx)
  );

  fa_alloc_sel #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)
  ) u_alloc (
    .valid_tbl (valid_q),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx),
    .victim_idx(victim_idx),
    .line_sel  (line_sel)
  );

  fa_ref_counters #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_ref   (ref_valid),
    .inc_miss  (fill_en),
    .ref_cnt_q (ref_count),
    .miss_cnt_q(miss_count)
  );

  // valid bits: only ever set by a fill, cleared by reset
  always_comb begin
    valid_d = valid_q;
    if (fill_en) valid_d[line_sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= '0;
    else if (fill_en) valid_q <= valid_d;
  end

  // tag storage: no reset needed, masked by valid
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (fill_en && (line_sel == IDX_W'(g))) tag_q[g] <= lookup_tag;
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= ref_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit  <= 1'b0;
      rsp_line <= '0;
    end else if (ref_valid) begin
      rsp_hit  <= hit_any;
      rsp_line <= line_sel;
    end
  end
endmodule

// File: rtl/fa_tag_dir_chk.sv
module fa_tag_dir_chk #(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2,
  parameter int CNT_W     = 16
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            ref_valid,
  input logic                            policy_sel,
  input logic                            rsp_valid,
  input logic                            rsp_hit,
  input logic [IDX_W-1:0]                rsp_line,
  input logic [CNT_W-1:0]                ref_count,
  input logic [CNT_W-1:0]                miss_count,
  input logic [NUM_LINES-1:0]            hit_vec,
  input logic [NUM_LINES-1:0]            valid_q,
  input logic [NUM_LINES-1:0][IDX_W-1:0] rank_q
);
  logic [NUM_LINES-1:0] rank_seen;
  logic [IDX_W-1:0]     low_free;
  logic [IDX_W-1:0]     oldest_line;
  logic [IDX_W-1:0]     newest_line;
  logic                 miss_now;
  logic                 full_now;

  assign miss_now = ref_valid && !(|hit_vec);
  assign full_now = &valid_q;

  always_comb begin
    rank_seen   = '0;
    low_free    = '0;
    oldest_line = '0;
    newest_line = '0;
    for (int i = 0; i < NUM_LINES; i++) rank_seen[rank_q[i]] = 1'b1;
    for (int i = NUM_LINES - 1; i >= 0; i--) if (!valid_q[i]) low_free = IDX_W'(i);
    for (int i = 0; i < NUM_LINES; i++) begin
      if (rank_q[i] == '0)                      oldest_line = IDX_W'(i);
      if (rank_q[i] == IDX_W'(NUM_LINES - 1))   newest_line = IDX_W'(i);
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |-> $onehot0(hit_vec)); // R11

  AST_RSP_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> rsp_valid); // R10

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> !rsp_valid); // R10

  AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> ref_count == $past(ref_count) + 1'b1); // R9

  AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> $stable(ref_count) && $stable(miss_count)); // R9

  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    miss_now |=> miss_count == $past(miss_count) + 1'b1); // R9

  AST_HIT_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !miss_now) |=> $stable(miss_count) && rsp_hit); // R3

  AST_FILL_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_now && !full_now) |=> rsp_line == $past(low_free)); // R4

  AST_EVICT_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_now && full_now && !policy_sel) |=> rsp_line == $past(oldest_line)); // R5

  AST_EVICT_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_now && full_now && policy_sel) |=> rsp_line == $past(newest_line)); // R6

  AST_TOUCH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> newest_line == rsp_line); // R7

  AST_RANK_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    &rank_seen); // R7

  AST_VALID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(valid_q) & ~valid_q) == '0); // R8
endmodule

bind fa_tag_dir fa_tag_dir_chk #(
  .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_valid (ref_valid),
  .policy_sel(policy_sel),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_line  (rsp_line),
  .ref_count (ref_count),
  .miss_count(miss_count),
  .hit_vec   (hit_vec),
  .valid_q   (valid_q),
  .rank_q    (rank_q)
);

// File: tb/fa_tag_dir_tb_top.sv
`timescale 1ns/1ps
module fa_tag_dir_tb_top;
  logic        clk;
  logic        rst_n;
  logic        ref_valid;
  logic [15:0] ref_addr;
  logic        policy_sel;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [1:0]  rsp_line;
  logic [15:0] ref_count;
  logic [15:0] miss_count;

  int n_checks = 0;
  int n_fail   = 0;

  // timestamp model
  int unsigned m_tag [4];
  bit          m_val [4];
  longint      m_time[4];
  longint      now_t;
  int unsigned exp_refs;
  int unsigned exp_miss;

  fa_tag_dir dut_i (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_addr(ref_addr),
    .policy_sel(policy_sel), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_line(rsp_line), .ref_count(ref_count), .miss_count(miss_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin m_val[i] = 0; m_tag[i] = 0; m_time[i] = 0; end
    now_t = 1; exp_refs = 0; exp_miss = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    ref_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_clear();
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", int'(rsp_valid), 0);
    chk(ref_count == 16'd0 && miss_count == 16'd0, "R1 counters in reset",
        int'(ref_count) + int'(miss_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one reference; result checked one edge later; note tags the case
  task automatic send(input logic [15:0] a, input string note);
    int    e_line;
    bit    e_hit;
    string req;
    longint best;
    e_hit = 0; e_line = -1;
    for (int i = 0; i < 4; i++)
      if (m_val[i] && m_tag[i] == int'(a[15:1])) begin e_hit = 1; e_line = i; end
    if (e_hit) req = "R3 hit";
    else begin
      for (int i = 3; i >= 0; i--) if (!m_val[i]) e_line = i;
      if (e_line >= 0) req = "R4 fill free";
      else begin
        e_line = 0; best = m_time[0];
        for (int i = 1; i < 4; i++) begin
          if (policy_sel ? (m_time[i] > best) : (m_time[i] < best)) begin
            best = m_time[i]; e_line = i;
          end
        end
        req = policy_sel ? "R6 evict newest" : "R5 evict oldest";
      end
      m_val[e_line] = 1; m_tag[e_line] = a[15:1];
      exp_miss++;
    end
    m_time[e_line] = now_t++;
    exp_refs++;
    ref_valid = 1'b1;
    ref_addr  = a;
    @(negedge clk);
    ref_valid = 1'b0;
    chk(rsp_valid == 1'b1, {"R10 ", note}, int'(rsp_valid), 1);
    chk(rsp_hit == e_hit, {req, " hit ", note}, int'(rsp_hit), int'(e_hit));
    chk(int'(rsp_line) == e_line, {req, " line ", note}, int'(rsp_line), e_line);
    chk(ref_count == exp_refs[15:0], {"R9 refs ", note}, int'(ref_count), int'(exp_refs[15:0]));
    chk(miss_count == exp_miss[15:0], {"R9 misses ", note}, int'(miss_count), int'(exp_miss[15:0]));
  endtask

  task automatic idle_check(input string note);
    logic [15:0] r0, m0;
    r0 = ref_count; m0 = miss_count;
    @(negedge clk);
    chk(rsp_valid == 1'b0, {"R10 idle ", note}, int'(rsp_valid), 0);
    chk(ref_count == r0 && miss_count == m0, {"R9 idle hold ", note},
        int'(ref_count), int'(r0));
  endtask

  initial begin
    #(5ns * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_valid = 1'b0; ref_addr = '0; policy_sel = 1'b0;
    model_clear();
    do_reset();

    // R1: first reference after reset fills line 0
    send(16'h0010, "R1 first");
    if (rsp_line != 2'd0) $display("note: R1 line mismatch reported above");
    // R2: sibling word of the same block hits
    send(16'h0011, "R2 offset");
    chk(rsp_hit == 1'b1 && rsp_line == 2'd0, "R2 same block", int'(rsp_line), 0);
    idle_check("after R2");

    // R7: fill A..D, touch A, miss must evict B (line 1) under oldest policy
    send(16'h0020, "R7"); send(16'h0030, "R7"); send(16'h0040, "R7");
    send(16'h0010, "R7 touch");
    send(16'h0050, "R7 evict");
    chk(rsp_line == 2'd1, "R7 order kept", int'(rsp_line), 1);

    // R8: switch policy; everything resident still hits
    policy_sel = 1'b1;
    idle_check("R8 switch");
    send(16'h0010, "R8"); send(16'h0050, "R8"); send(16'h0030, "R8"); send(16'h0040, "R8");
    chk(rsp_hit == 1'b1, "R8 still resident", int'(rsp_hit), 1);
    send(16'h0060, "R6 directed");
    chk(rsp_line == 2'd3, "R6 newest is last touched", int'(rsp_line), 3);

    // cyclic sweeps over more blocks than lines, both policies
    for (int p = 0; p < 2; p++) begin
      policy_sel = p[0];
      for (int rep = 0; rep < 4; rep++)
        for (int b = 0; b < 6; b++) send(16'(16'h0100 + 2 * b + rep % 2), "sweep");
    end

    // random stream over 8 blocks, policy toggling (R8), idle gaps (R10)
    for (int k = 0; k < 3000; k++) begin
      if (k % 37 == 0) policy_sel = ~policy_sel;
      send(16'(16'h0200 + ($urandom % 16)), "random");
      if (k % 101 == 0) idle_check("random gap");
    end

    // R1: reset mid-run clears contents
    do_reset();
    send(16'h0200, "R1 after reset");
    chk(rsp_hit == 1'b0 && rsp_line == 2'd0, "R1 cleared", int'(rsp_hit), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule